// File: doc/BRIEF.md
# Broadcast-Message Boot Processor Election Controller

Each processor in a multiprocessor system carries one copy of this controller. After its built-in self-test finishes, the controller sends a boot-election message onto a shared, ordered message bus, addressed to every processor including the sender. The bus delivers one message per slot, in a single order that every processor sees the same way. A controller that sees its own election message come back before any other election message takes the bootstrap role. A controller that sees some other sender's election message first takes the application role and withdraws its own pending request.

The elected bootstrap controller then sends a single end-of-election message. Every controller treats that message as the end of multiprocessor setup. Only the bootstrap controller acts on it, by issuing a fetch request at the reset vector. Application controllers stay in a waiting state until a startup message arrives. The startup message carries an 8-bit vector VV, and the waiting controller then fetches from 0x000VV000. The roles and the fetch request are the block's outputs. It has no other state visible to software.

Top module: `boot_elect_top`

## Requirements
- R1: After reset, isBoot, isApp, apWaiting, txValid and fetchValid are all 0.
- R2: A one-cycle selfTestDone pulse makes txValid high with txKind = 2'b01 (election) and txSender = myId in the next cycle. The request stays high until txGrant is sampled high alongside it, then drops.
- R3: An election message (rxKind = 2'b01) received with rxSender = myId after the controller's own election was granted sets isBoot in the next cycle. isApp stays 0.
- R4: An election message from another sender, received before the controller's own message has returned, sets isApp and apWaiting in the next cycle. This holds whether or not the controller's request has been granted yet. Any pending election request is withdrawn (txValid 0 in that cycle).
- R5: One cycle after isBoot rises, txValid goes high with txKind = 2'b10 (final). It is held until granted and is never sent again.
- R6: The bootstrap controller, on receiving a final message (rxKind = 2'b10), raises fetchValid for exactly one cycle with fetchAddr = 0xFFFF_FFF0 in the next cycle.
- R7: An application controller that receives a final message issues no fetch and keeps apWaiting at 1.
- R8: A waiting application controller that receives a startup message (rxKind = 2'b11) with vector VV raises fetchValid for one cycle with fetchAddr = 0x000VV000, and clears apWaiting.
- R9: isBoot and isApp are never both 1. Once set, a role holds until reset. The bootstrap controller ignores startup messages.
- R10: Once a role is fixed, later election messages have no effect, including the controller's own echo arriving after it became an application processor.
- R11: An election message from another sender seen before self-test completes also makes the controller an application processor. It then never requests an election broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| myId | input | ID_W | This processor's bus identity |
| selfTestDone | input | 1 | One-cycle pulse when self-test completes |
| txValid | output | 1 | Request to send a message in the next bus slot |
| txKind | output | 2 | Kind of message requested (01 election, 10 final) |
| txSender | output | ID_W | Sender ID attached to the outgoing message |
| txGrant | input | 1 | Bus accepted the requested message this cycle |
| rxValid | input | 1 | A message is delivered in this slot |
| rxKind | input | 2 | Kind of delivered message (01 election, 10 final, 11 startup) |
| rxSender | input | ID_W | Sender of the delivered message |
| rxVector | input | VEC_W | Startup vector of the delivered message |
| isBoot | output | 1 | Bootstrap role flag |
| isApp | output | 1 | Application role flag |
| apWaiting | output | 1 | Application processor waiting for startup |
| fetchValid | output | 1 | One-cycle fetch request |
| fetchAddr | output | 32 | Address of the fetch request |

## Verification
The hardest case to reach is a lost race: the controller's own election message has already been granted onto the bus, and another sender's election overtakes it before the echo returns. The echo then arrives after the role is fixed and must be ignored. The bench reaches this case by granting the request and delivering a foreign election in the following slot. It then replays the controller's own echo and checks that neither role flag nor the fetch output moves. A scoreboard queue holds each fetch address the bench expects, so any unexpected fetch from a final or startup message is caught, as is any missing one.

// File: rtl/boot_elect_pkg.sv
package boot_elect_pkg;

  typedef enum logic [1:0] {
    MSG_NONE  = 2'b00,
    MSG_ELECT = 2'b01,
    MSG_FINAL = 2'b10,
    MSG_START = 2'b11
  } msgKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic txElect;
    logic txFinal;
    logic setBoot;
    logic setApp;
    logic clrWait;
    logic fetchReset;
    logic fetchStart;
  } ctlStrobe_t;

  // datapath -> control decoded receive events
  typedef struct packed {
    logic ownElect;
    logic otherElect;
    logic gotFinal;
    logic gotStart;
  } rxEvent_t;

endpackage

// File: rtl/boot_elect_ctrl.sv
module boot_elect_ctrl
  import boot_elect_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selfTestDone,
  input  logic       txGrant,
  input  rxEvent_t   rxEv,
  output ctlStrobe_t strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_SENT, ST_CLAIM, ST_FINAL, ST_BOOTWAIT, ST_APWAIT, ST_RUN
  } state_t;

  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    strb.txElect = (state == ST_ARM);
    strb.txFinal = (state == ST_FINAL);
    unique case (state)
      ST_IDLE: begin
        if (rxEv.otherElect) begin
          stateNext   = ST_APWAIT;
          strb.setApp = 1'b1;
        end else if (selfTestDone) begin
          stateNext = ST_ARM;
        end
      end
      ST_ARM: begin
        if (rxEv.otherElect) begin
          stateNext    = ST_APWAIT;
          strb.setApp  = 1'b1;
        end else if (txGrant) begin
          stateNext = ST_SENT;
        end
      end
      ST_SENT: begin
        if (rxEv.ownElect) begin
          stateNext    = ST_CLAIM;
          strb.setBoot = 1'b1;
        end else if (rxEv.otherElect) begin
          stateNext   = ST_APWAIT;
          strb.setApp = 1'b1;
        end
      end
      ST_CLAIM:    stateNext = ST_FINAL;
      ST_FINAL:    if (txGrant) stateNext = ST_BOOTWAIT;
      ST_BOOTWAIT: begin
        if (rxEv.gotFinal) begin
          stateNext       = ST_RUN;
          strb.fetchReset = 1'b1;
        end
      end
      ST_APWAIT: begin
        if (rxEv.gotStart) begin
          stateNext       = ST_RUN;
          strb.fetchStart = 1'b1;
          strb.clrWait    = 1'b1;
        end
      end
      ST_RUN:  stateNext = ST_RUN;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R2: an ungranted, uncontested election request is held
  p_elect_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txElect && !txGrant && !rxEv.otherElect) |=> strb.txElect);

  // R4: a foreign election during the race withdraws our request
  p_ap_cancel_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ARM || state == ST_SENT) && rxEv.otherElect && !rxEv.ownElect)
      |=> (!strb.txElect && state == ST_APWAIT));

  // R5: the final request is offered only once
  p_final_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txFinal && txGrant) |=> !strb.txFinal);

  // R10: own echo after becoming AP never claims boot
  p_no_late_claim_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_APWAIT) |-> !strb.setBoot);

endmodule

// File: rtl/boot_elect_dp.sv
module boot_elect_dp
  import boot_elect_pkg::*;
#(
  parameter int          ID_W        = 4,
  parameter int          VEC_W       = 8,
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] RESET_VEC   = 32'hFFFF_FFF0,
  parameter int          START_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   myId,
  input  logic              rxValid,
  input  logic [1:0]        rxKind,
  input  logic [ID_W-1:0]   rxSender,
  input  logic [VEC_W-1:0]  rxVector,
  input  logic              txGrant,
  input  ctlStrobe_t        strb,
  output rxEvent_t          rxEv,
  output logic              txValid,
  output logic [1:0]        txKind,
  output logic [ID_W-1:0]   txSender,
  output logic              isBoot,
  output logic              isApp,
  output logic              apWaiting,
  output logic              fetchValid,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(RESET_VEC);

  logic              senderIsMe;
  logic [ADDR_W-1:0] startAddr;
  logic              bootQ, appQ, waitQ, fetchQ;
  logic [ADDR_W-1:0] addrQ;

  assign senderIsMe = (rxSender == myId);
  assign startAddr  = ADDR_W'(rxVector) << START_SHIFT;

  always_comb begin
    rxEv.ownElect   = rxValid && (rxKind == MSG_ELECT) &&  senderIsMe;
    rxEv.otherElect = rxValid && (rxKind == MSG_ELECT) && !senderIsMe;
    rxEv.gotFinal   = rxValid && (rxKind == MSG_FINAL);
    rxEv.gotStart   = rxValid && (rxKind == MSG_START);
  end

  assign txValid  = strb.txElect | strb.txFinal;
  assign txKind   = strb.txFinal ? MSG_FINAL : (strb.txElect ? MSG_ELECT : MSG_NONE);
  assign txSender = myId;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootQ  <= 1'b0;
      appQ   <= 1'b0;
      waitQ  <= 1'b0;
      fetchQ <= 1'b0;
      addrQ  <= '0;
    end else begin
      if (strb.setBoot) bootQ <= 1'b1;
      if (strb.setApp) begin
        appQ  <= 1'b1;
        waitQ <= 1'b1;
      end
      if (strb.clrWait) waitQ <= 1'b0;
      fetchQ <= strb.fetchReset | strb.fetchStart;
      if (strb.fetchReset)      addrQ <= RESET_ADDR;
      else if (strb.fetchStart) addrQ <= startAddr;
    end
  end

  assign isBoot     = bootQ;
  assign isApp      = appQ;
  assign apWaiting  = waitQ;
  assign fetchValid = fetchQ;
  assign fetchAddr  = addrQ;

  // R9: roles exclusive and sticky
  p_role_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(isBoot && isApp));
  p_boot_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    isBoot |=> isBoot);
  p_app_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    isApp |=> isApp);

  // R5: final request follows the flag by one cycle
  p_final_after_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isBoot) |=> (txValid && txKind == MSG_FINAL));

  // R6: fetch is a single-cycle pulse; boot fetch targets the reset vector
  p_fetch_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> !fetchValid);
  p_boot_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && isBoot) |-> (fetchAddr == RESET_ADDR));

  // R8: startup fetch ends the wait
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && isApp) |-> !apWaiting);

endmodule

// File: rtl/boot_elect_top.sv
module boot_elect_top
  import boot_elect_pkg::*;
#(
  parameter int          ID_W        = 4,
  parameter int          VEC_W       = 8,
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] RESET_VEC   = 32'hFFFF_FFF0,
  parameter int          START_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   myId,
  input  logic              selfTestDone,
  output logic              txValid,
  output logic [1:0]        txKind,
  output logic [ID_W-1:0]   txSender,
  input  logic              txGrant,
  input  logic              rxValid,
  input  logic [1:0]        rxKind,
  input  logic [ID_W-1:0]   rxSender,
  input  logic [VEC_W-1:0]  rxVector,
  output logic              isBoot,
  output logic              isApp,
  output logic              apWaiting,
  output logic              fetchValid,
  output logic [ADDR_W-1:0] fetchAddr
);

  ctlStrobe_t strb;
  rxEvent_t   rxEv;

  boot_elect_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .selfTestDone (selfTestDone),
    .txGrant      (txGrant),
    .rxEv         (rxEv),
    .strb         (strb)
  );

  boot_elect_dp #(
    .ID_W        (ID_W),
    .VEC_W       (VEC_W),
    .ADDR_W      (ADDR_W),
    .RESET_VEC   (RESET_VEC),
    .START_SHIFT (START_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .myId       (myId),
    .rxValid    (rxValid),
    .rxKind     (rxKind),
    .rxSender   (rxSender),
    .rxVector   (rxVector),
    .txGrant    (txGrant),
    .strb       (strb),
    .rxEv       (rxEv),
    .txValid    (txValid),
    .txKind     (txKind),
    .txSender   (txSender),
    .isBoot     (isBoot),
    .isApp      (isApp),
    .apWaiting  (apWaiting),
    .fetchValid (fetchValid),
    .fetchAddr  (fetchAddr)
  );

endmodule

// File: tb/sim_boot_elect_top.sv
`timescale 1ns/1ps
module sim_boot_elect_top;

  localparam logic [3:0] ME    = 4'd5;
  localparam logic [3:0] OTHER = 4'd9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  myId = ME;
  logic        selfTestDone = 1'b0;
  logic        txValid;
  logic [1:0]  txKind;
  logic [3:0]  txSender;
  logic        txGrant = 1'b0;
  logic        rxValid = 1'b0;
  logic [1:0]  rxKind = 2'b00;
  logic [3:0]  rxSender = 4'd0;
  logic [7:0]  rxVector = 8'd0;
  logic        isBoot, isApp, apWaiting, fetchValid;
  logic [31:0] fetchAddr;

  int total = 0;
  int bad   = 0;
  logic [31:0] expQ[$];

  always #2.5 clk = ~clk;

  boot_elect_top u0 (
    .clk(clk), .rstN(rstN), .myId(myId), .selfTestDone(selfTestDone),
    .txValid(txValid), .txKind(txKind), .txSender(txSender), .txGrant(txGrant),
    .rxValid(rxValid), .rxKind(rxKind), .rxSender(rxSender), .rxVector(rxVector),
    .isBoot(isBoot), .isApp(isApp), .apWaiting(apWaiting),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: every fetch must match the next expected address
  always @(negedge clk) begin
    if (rstN && fetchValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R6/R7/R8/R9 unexpected fetch act=%h exp=none", fetchAddr);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        if (fetchAddr !== e) begin
          bad++;
          $display("FAIL R6/R8 fetch act=%h exp=%h", fetchAddr, e);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  task automatic pulseSelfTest();
    selfTestDone = 1'b1; step(); selfTestDone = 1'b0;
  endtask

  task automatic grant();
    txGrant = 1'b1; step(); txGrant = 1'b0;
  endtask

  task automatic sendRx(input logic [1:0] k, input logic [3:0] s, input logic [7:0] v);
    rxValid = 1'b1; rxKind = k; rxSender = s; rxVector = v;
    step();
    rxValid = 1'b0; rxKind = 2'b00; rxSender = 4'd0; rxVector = 8'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 isBoot", isBoot, 0);
    chk("R1 isApp", isApp, 0);
    chk("R1 apWaiting", apWaiting, 0);
    chk("R1 txValid", txValid, 0);
    chk("R1 fetchValid", fetchValid, 0);

    // ---- boot path ----
    pulseSelfTest();
    chk("R2 txValid", txValid, 1);
    chk("R2 txKind elect", txKind, 2'b01);
    chk("R2 txSender", txSender, ME);
    step(); step();
    chk("R2 held", txValid, 1);
    grant();
    chk("R2 dropped after grant", txValid, 0);
    sendRx(2'b01, ME, 8'h00);
    chk("R3 isBoot", isBoot, 1);
    chk("R3 isApp", isApp, 0);
    chk("R5 not yet", txValid, 0);
    step();
    chk("R5 final valid", txValid, 1);
    chk("R5 final kind", txKind, 2'b10);
    step();
    chk("R5 final held", txValid, 1);
    grant();
    chk("R5 final dropped", txValid, 0);
    repeat (3) step();
    chk("R5 never resent", txValid, 0);
    expQ.push_back(32'hFFFF_FFF0);
    sendRx(2'b10, ME, 8'h00);   // R6
    step();
    sendRx(2'b11, OTHER, 8'h42); // R9: boot ignores startup
    step();
    chk("R9 boot kept", isBoot, 1);
    chk("R6 queue drained", expQ.size(), 0);

    // ---- AP: foreign election before grant ----
    doReset();
    pulseSelfTest();
    sendRx(2'b01, OTHER, 8'h00);
    chk("R4 isApp", isApp, 1);
    chk("R4 waiting", apWaiting, 1);
    chk("R4 withdrawn", txValid, 0);
    sendRx(2'b10, OTHER, 8'h00); // R7
    step();
    chk("R7 still waiting", apWaiting, 1);
    sendRx(2'b01, ME, 8'h00);    // R10
    chk("R10 no boot", isBoot, 0);
    chk("R10 still app", isApp, 1);
    expQ.push_back(32'h000A_5000);
    sendRx(2'b11, OTHER, 8'hA5); // R8
    chk("R8 wait cleared", apWaiting, 0);
    step();
    chk("R8 queue drained", expQ.size(), 0);

    // ---- AP: lost race after grant ----
    doReset();
    pulseSelfTest();
    grant();
    sendRx(2'b01, OTHER, 8'h00);
    chk("R4 after grant isApp", isApp, 1);
    sendRx(2'b01, ME, 8'h00);
    chk("R10 late echo ignored", isBoot, 0);
    step();
    chk("R10 no tx", txValid, 0);

    // ---- AP: foreign election before self-test ----
    doReset();
    sendRx(2'b01, OTHER, 8'h00);
    chk("R11 isApp", isApp, 1);
    pulseSelfTest();
    chk("R11 no request", txValid, 0);
    expQ.push_back(32'h0000_0000);
    sendRx(2'b11, OTHER, 8'h00);
    step(); step();
    chk("R11 queue drained", expQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule